// File: doc/BRIEF.md
# Two-Step Power-Down Entry Controller

This block decides when a small microcontroller may drop into power-down. Software must first write the power-control register with the arm bit set. In the very next instruction it must write the register again with the start bit set. The block watches byte writes to that register and the CPU core's instruction-retire strobe. When the two writes arrive in order, it shuts off the clock-run enable, raises a power-down status output and forces the address-latch and program-store strobes low.

A single write that sets both request bits is rejected. So is a start write with no arm before it, and so is an arm that is followed by any other instruction. The two request bits are never stored and always read back as zero. The remaining register bits are ordinary storage.

Once power-down is entered it holds. Writes and retire strobes have no effect until the hardware reset input is asserted. Reset puts the register back into its reset state and restarts the clocks. All pins are plain control and status signals. The write port has no handshake: a selected write is always taken in the cycle it is presented.

Top module: `pdc_power_down_ctrl`

## Requirements
- R1: While reset is held and after it is released, sfr_rd_data is 0, pd_active is 0 and clk_run is 1.
- R2: Bit 1 (arm) and bit 6 (start) of sfr_rd_data always read 0, whatever was written.
- R3: A write with sfr_sel and sfr_wr_en both high stores every bit except bits 1 and 6, and sfr_rd_data shows it from the next clock edge. A write with either strobe low changes nothing.
- R4: An instruction that writes a byte with bit 1 set and bit 6 clear, followed directly by an instruction that writes a byte with bit 6 set and bit 1 clear, enters power-down. pd_active goes to 1 and clk_run to 0 at the clock edge that samples insn_retire high for the start instruction, and not earlier.
- R5: A write with both bit 1 and bit 6 set never enters power-down. It also cancels any pending arm.
- R6: A write with bit 6 set and bit 1 clear does not enter power-down unless the instruction directly before it wrote the arm pattern.
- R7: The arm state lapses at the retire of the next instruction unless that instruction wrote the start pattern. This holds for an instruction that performs no write and for one that writes only other bits.
- R8: An arm write followed by another arm write leaves the block armed, so a start write in the instruction after the second arm enters power-down.
- R9: While pd_active is 1, ale_out and psen_out are 0. Otherwise they follow core_ale and core_psen.
- R10: Once entered, power-down stays in force and sfr_rd_data is frozen. Writes and retire strobes are ignored. Only rst_n low leaves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| sfr_sel | input | 1 | Address match for the power-control register |
| sfr_wr_en | input | 1 | Write enable for the register |
| sfr_wr_data | input | 8 | Byte written to the register |
| sfr_rd_data | output | 8 | Register read value, request bits forced to 0 |
| insn_retire | input | 1 | One-cycle strobe marking the end of an instruction |
| core_ale | input | 1 | Address-latch strobe from the core |
| core_psen | input | 1 | Program-store strobe from the core |
| clk_run | output | 1 | Clock-run enable, 0 in power-down |
| pd_active | output | 1 | Power-down status |
| ale_out | output | 1 | Address-latch strobe to the pins |
| psen_out | output | 1 | Program-store strobe to the pins |

## Verification
Register contents, pd_active and clk_run are all registered. A write or retire presented in one cycle therefore shows up one clock edge later: sfr_rd_data after the edge that takes the write, and pd_active/clk_run after the edge that samples the start instruction's retire. ale_out and psen_out follow pd_active with no extra delay. The bench drives inputs on the falling edge and samples on the following falling edge, so each check lands half a cycle after the edge at which its result becomes due. For multi-cycle instructions it samples pd_active just before the retire cycle to confirm that nothing moves early.

// File: rtl/pdc_pkg.sv
`timescale 1ns/1ps
package pdc_pkg;
  localparam int unsigned PDC_REG_W     = 8;
  localparam int unsigned PDC_ARM_POS   = 1;
  localparam int unsigned PDC_START_POS = 6;
  localparam int unsigned PDC_N_STROBE  = 2;

  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_ARM   = 2'd1,
    REQ_START = 2'd2,
    REQ_BOTH  = 2'd3
  } req_kind_e;

  function automatic req_kind_e classify_req(input logic arm, input logic start);
    if (arm && start) return REQ_BOTH;
    if (arm)          return REQ_ARM;
    if (start)        return REQ_START;
    return REQ_NONE;
  endfunction
endpackage

// File: rtl/pdc_ctrl_reg.sv
`timescale 1ns/1ps
module pdc_ctrl_reg #(
  parameter int unsigned W         = 8,
  parameter int unsigned ARM_POS   = 1,
  parameter int unsigned START_POS = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data
);
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] REQ_MASK = (ONE << ARM_POS) | (ONE << START_POS);

  logic [W-1:0] store_q;

  // request bits are never kept; everything else is plain storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      store_q <= '0;
    else if (wr_stb) store_q <= wr_data & ~REQ_MASK;
  end

  assign rd_data = store_q;

  p_store_follows_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (rd_data == ($past(wr_data) & ~REQ_MASK)));
  p_store_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(rd_data));
endmodule

// File: rtl/pdc_entry_seq.sv
`timescale 1ns/1ps
module pdc_entry_seq
  import pdc_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned ARM_POS   = 1,
  parameter int unsigned START_POS = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  input  logic         retire,
  output logic         pd_q,
  output logic         clk_run_q
);
  req_kind_e kind;
  logic armed_q;   // previous instruction wrote the arm pattern
  logic arm_cur_q; // current instruction has written the arm pattern
  logic go_cur_q;  // current instruction has written a valid start
  logic arm_cur_n, go_cur_n;

  always_comb begin
    kind      = wr_stb ? classify_req(wr_data[ARM_POS], wr_data[START_POS]) : REQ_NONE;
    arm_cur_n = arm_cur_q;
    go_cur_n  = go_cur_q;
    case (kind)
      REQ_ARM:   begin arm_cur_n = 1'b1; go_cur_n = 1'b0;    end
      REQ_START: begin arm_cur_n = 1'b0; go_cur_n = armed_q; end
      REQ_BOTH:  begin arm_cur_n = 1'b0; go_cur_n = 1'b0;    end
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      arm_cur_q <= 1'b0;
      go_cur_q  <= 1'b0;
      pd_q      <= 1'b0;
      clk_run_q <= 1'b1;
    end else if (!pd_q) begin
      if (retire) begin
        armed_q   <= arm_cur_n;
        pd_q      <= go_cur_n;
        clk_run_q <= ~go_cur_n;
        arm_cur_q <= 1'b0;
        go_cur_q  <= 1'b0;
      end else begin
        arm_cur_q <= arm_cur_n;
        go_cur_q  <= go_cur_n;
      end
    end
  end

  p_entry_on_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_q) |-> $past(retire));
  p_entry_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_q) |-> $past(armed_q));
  p_clock_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |-> !clk_run_q);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |=> pd_q);
endmodule

// File: rtl/pdc_strobe_gate.sv
`timescale 1ns/1ps
module pdc_strobe_gate #(
  parameter int unsigned N = 2
) (
  input  logic         hold_low,
  input  logic [N-1:0] strobe_in,
  output logic [N-1:0] strobe_out
);
  for (genvar i = 0; i < N; i++) begin : g_gate
    assign strobe_out[i] = strobe_in[i] & ~hold_low;
  end
endmodule

// File: rtl/pdc_power_down_ctrl.sv
`timescale 1ns/1ps
module pdc_power_down_ctrl
  import pdc_pkg::*;
#(
  parameter int unsigned REG_W     = PDC_REG_W,
  parameter int unsigned ARM_POS   = PDC_ARM_POS,
  parameter int unsigned START_POS = PDC_START_POS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sfr_sel,
  input  logic             sfr_wr_en,
  input  logic [REG_W-1:0] sfr_wr_data,
  output logic [REG_W-1:0] sfr_rd_data,
  input  logic             insn_retire,
  input  logic             core_ale,
  input  logic             core_psen,
  output logic             clk_run,
  output logic             pd_active,
  output logic             ale_out,
  output logic             psen_out
);
  localparam int unsigned NS = PDC_N_STROBE;

  logic          wr_stb;
  logic [NS-1:0] strobes_in, strobes_out;

  // nothing is written once the clocks are meant to be stopped
  assign wr_stb = sfr_sel & sfr_wr_en & ~pd_active;

  pdc_ctrl_reg #(.W(REG_W), .ARM_POS(ARM_POS), .START_POS(START_POS)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(sfr_wr_data),
    .rd_data(sfr_rd_data)
  );

  pdc_entry_seq #(.W(REG_W), .ARM_POS(ARM_POS), .START_POS(START_POS)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(sfr_wr_data),
    .retire(insn_retire), .pd_q(pd_active), .clk_run_q(clk_run)
  );

  assign strobes_in = {core_psen, core_ale};

  pdc_strobe_gate #(.N(NS)) u_gate (
    .hold_low(pd_active), .strobe_in(strobes_in), .strobe_out(strobes_out)
  );

  assign ale_out  = strobes_out[0];
  assign psen_out = strobes_out[1];

  p_req_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_rd_data[ARM_POS] && !sfr_rd_data[START_POS]);
  p_strobes_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |-> (!ale_out && !psen_out));
  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && $past(pd_active)) |-> $stable(sfr_rd_data));
endmodule

// File: tb/pdc_power_down_ctrl_tb.sv
`timescale 1ns/1ps
module pdc_power_down_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sfr_sel = 1'b0, sfr_wr_en = 1'b0, insn_retire = 1'b0;
  logic [7:0] sfr_wr_data = 8'h00;
  logic       core_ale = 1'b1, core_psen = 1'b1;
  logic [7:0] sfr_rd_data;
  logic       clk_run, pd_active, ale_out, psen_out;
  int total = 0, bad = 0;
  bit finished = 0;

  localparam logic [7:0] REQ_MASK = 8'h42; // bit 1 arm, bit 6 start

  always #4 clk = ~clk; // 125 MHz

  pdc_power_down_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_sel(sfr_sel), .sfr_wr_en(sfr_wr_en),
    .sfr_wr_data(sfr_wr_data), .sfr_rd_data(sfr_rd_data), .insn_retire(insn_retire),
    .core_ale(core_ale), .core_psen(core_psen), .clk_run(clk_run),
    .pd_active(pd_active), .ale_out(ale_out), .psen_out(psen_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive after a falling edge, hold across the rising edge
  task automatic step(input logic sel, input logic we, input logic [7:0] d, input logic ret);
    sfr_sel = sel; sfr_wr_en = we; sfr_wr_data = d; insn_retire = ret;
    @(posedge clk); @(negedge clk);
    sfr_sel = 1'b0; sfr_wr_en = 1'b0; insn_retire = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d, input logic ret);
    step(1'b1, 1'b1, d, ret);
  endtask

  task automatic idle(input logic ret);
    step(1'b0, 1'b0, 8'h00, ret);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic expect_pd(input string req, input logic exp_pd);
    check(req, {31'd0, pd_active}, {31'd0, exp_pd});
    check(req, {31'd0, clk_run}, {31'd0, ~exp_pd});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    check("R1 rd in reset", {24'd0, sfr_rd_data}, 32'h0);
    expect_pd("R1 in reset", 1'b0);
    do_reset();
    check("R1 rd after reset", {24'd0, sfr_rd_data}, 32'h0);
    expect_pd("R1 after reset", 1'b0);
    check("R9 ale pass", {31'd0, ale_out}, 32'd1);
    check("R9 psen pass", {31'd0, psen_out}, 32'd1);

    // R3 ignored writes
    step(1'b0, 1'b1, 8'hA5, 1'b1);
    check("R3 sel low ignored", {24'd0, sfr_rd_data}, 32'h0);
    step(1'b1, 1'b0, 8'hA5, 1'b1);
    check("R3 wr_en low ignored", {24'd0, sfr_rd_data}, 32'h0);

    // sweep: every first byte against four request patterns in the second byte
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] b, fa, fb;
        logic exp_pd;
        b = (~a[7:0] & ~REQ_MASK) | (k[0] ? 8'h02 : 8'h00) | (k[1] ? 8'h40 : 8'h00);
        fa = a[7:0] & ~REQ_MASK;
        fb = b & ~REQ_MASK;
        exp_pd = (a[1] & ~a[6]) & (b[6] & ~b[1]);
        do_reset();
        wr(a[7:0], 1'b1);
        check("R2 R3 first byte read", {24'd0, sfr_rd_data}, {24'd0, fa});
        check("R5 R6 no entry on first", {31'd0, pd_active}, 32'd0);
        wr(b, 1'b1);
        check("R2 R3 second byte read", {24'd0, sfr_rd_data}, {24'd0, fb});
        expect_pd("R4 R5 R6 entry decision", exp_pd);
        check("R9 ale", {31'd0, ale_out}, {31'd0, ~exp_pd});
        check("R9 psen", {31'd0, psen_out}, {31'd0, ~exp_pd});
        if (exp_pd) begin
          wr(8'hFF, 1'b1);
          check("R10 write ignored", {24'd0, sfr_rd_data}, {24'd0, fb});
          expect_pd("R10 stays", 1'b1);
        end
      end
    end

    // R7 an idle instruction in between disarms
    do_reset();
    wr(8'h02, 1'b1); idle(1'b1); wr(8'h40, 1'b1);
    expect_pd("R7 idle instruction disarms", 1'b0);
    // R7 writing other bits in between disarms
    do_reset();
    wr(8'h02, 1'b1); wr(8'h81, 1'b1); wr(8'h40, 1'b1);
    expect_pd("R7 other-bit write disarms", 1'b0);
    check("R3 other bits kept", {24'd0, sfr_rd_data}, 32'h0);
    // R5 both bits after arm cancel the arm
    do_reset();
    wr(8'h02, 1'b1); wr(8'h42, 1'b1); wr(8'h40, 1'b1);
    expect_pd("R5 both cancels arm", 1'b0);
    // R8 re-arm
    do_reset();
    wr(8'h02, 1'b1); wr(8'h02, 1'b1); wr(8'h40, 1'b1);
    expect_pd("R8 rearm then start", 1'b1);
    // R4 multi-cycle instructions: entry waits for the start instruction's retire
    do_reset();
    wr(8'h02, 1'b0); idle(1'b0); idle(1'b1);
    wr(8'h40, 1'b0); idle(1'b0);
    expect_pd("R4 not before retire", 1'b0);
    idle(1'b1);
    expect_pd("R4 at retire", 1'b1);
    // R10 retire strobes and strobe inputs during power-down; reset leaves it
    core_ale = 1'b1; core_psen = 1'b1;
    idle(1'b1); idle(1'b1);
    expect_pd("R10 retire ignored", 1'b1);
    check("R9 ale forced", {31'd0, ale_out}, 32'd0);
    do_reset();
    expect_pd("R10 reset exits", 1'b0);
    check("R1 rd after exit", {24'd0, sfr_rd_data}, 32'h0);
    core_ale = 1'b0; core_psen = 1'b1;
    #1;
    check("R9 ale follows core", {31'd0, ale_out}, 32'd0);
    check("R9 psen follows core", {31'd0, psen_out}, 32'd1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule